// File: doc/BRIEF.md
# Dual-Clock Up/Down Counter

This block is a W-bit (4 by default) binary counter that is stepped by two separate count inputs, one that advances the value and one that retreats it, rather than by a single clock and a direction bit. A free-running system clock samples both count inputs. A step is taken when a rising edge is seen on one count input while the other is resting high. A clear input and an active-low load input override the counter. They show on the count output in the same cycle they are applied, without waiting for a count edge or a system clock edge.

Two active-low cascade outputs let several of these blocks be chained. The carry output drops while the count sits at its top value and the advancing input is in its low phase. The borrow output drops while the count sits at zero and the retreating input is in its low phase. Each pulse therefore rises together with the count input that feeds the next stage, so that input edge becomes the next stage's step edge. The block takes a synchronous active-low reset. The count inputs are expected to toggle at no more than half the system clock rate. They must already be synchronous to the system clock.

Top module: `bidir_step_counter`

## Requirements
- R1: While `clr` is high, `count` reads 0 in the same cycle, before any clock edge. The stored value is 0 once `clr` has been seen by a system clock edge.
- R2: While `clr` is low and `load_n` is low, `count` equals `din` in the same cycle, before any clock edge. For example, `din` = 4'b1101 reads as 13.
- R3: With `dn_in` high, a rising edge on `up_in` raises the count by one after the system clock edge that samples it. 15 wraps to 0.
- R4: With `up_in` high, a rising edge on `dn_in` lowers the count by one after the system clock edge that samples it. 0 wraps to 15.
- R5: `carry_n` is low exactly while `count` is all ones and `up_in` is low. Its low pulse lasts as long as the low phase of `up_in`, counted in system clock cycles.
- R6: `borrow_n` is low exactly while `count` is 0 and `dn_in` is low. Its low pulse lasts as long as the low phase of `dn_in`.
- R7: `clr` overrides `load_n`, and both override counting. A count edge that arrives while either is active is discarded.
- R8: A rising edge on either count input is ignored while the other count input is low.
- R9: When both count inputs rise in the same system clock cycle, the count is unchanged.
- R10: After reset, with both count inputs high, `count` is 0, `carry_n` is high and `borrow_n` is high.
- R11: After `load_n` returns high, the loaded value is held until the next valid count edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock that samples the count inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| up_in | input | 1 | Advancing count input; its rising edge steps up |
| dn_in | input | 1 | Retreating count input; its rising edge steps down |
| clr | input | 1 | Active-high clear, visible at once |
| load_n | input | 1 | Active-low parallel load, visible at once |
| din | input | W | Parallel load value |
| count | output | W | Current count |
| carry_n | output | 1 | Active-low carry, low while at all ones and up_in is low |
| borrow_n | output | 1 | Active-low borrow, low while at zero and dn_in is low |

## Verification
The two functions that can land in one cycle are a count step and a clear or load override. Both count inputs can also rise in the same cycle. The bench provokes the first case by raising `up_in` in the same half-cycle that `load_n` is driven low with a new value. It then checks that the loaded value, not the loaded value plus one, survives after `load_n` is released. It provokes the second case by lowering both count inputs and then raising them together, and it judges that the count is unchanged.

// File: rtl/bsc_pkg.sv
// Package: shared types for the dual-input step counter.
// Assumes: nothing beyond IEEE 1800-2017.
package bsc_pkg;

    // Step decision produced each system clock cycle.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    // Number of count-input lanes (advance and retreat).
    localparam int unsigned LANES = 2;
    localparam int unsigned LANE_UP = 0;
    localparam int unsigned LANE_DN = 1;

endpackage

// File: rtl/bsc_edge_detect.sv
// Module: bsc_edge_detect
// Flags a rising edge on a level input by comparing it with the value
// held from the previous system clock. The history resets to IDLE so
// that an input resting at its idle level produces no edge after reset.
// Assumes: pin_i is synchronous to clk and stays stable for at least
// one clock per level.
module bsc_edge_detect #(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);

    logic prev_q;

    // Hold the last sampled level of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= IDLE;
        end else begin
            prev_q <= pin_i;
        end
    end

    // Rising edge: high now, low last cycle.
    always_comb begin
        rise_o = pin_i & ~prev_q;
    end

endmodule

// File: rtl/bsc_step_decode.sv
// Module: bsc_step_decode
// Turns the two edge flags into one step decision. An edge counts only
// while the opposite count input rests high. If both qualify in one
// cycle, they cancel and the count holds.
// Assumes: edge flags come from bsc_edge_detect on the same pins.
module bsc_step_decode
    import bsc_pkg::*;
(
    input  logic  up_pin,
    input  logic  dn_pin,
    input  logic  up_rise,
    input  logic  dn_rise,
    output step_e step_o
);

    logic inc_ok;
    logic dec_ok;

    // Qualify each edge with the other input's level.
    always_comb begin
        inc_ok = up_rise & dn_pin;
        dec_ok = dn_rise & up_pin;
    end

    // Choose the step; simultaneous qualified edges cancel.
    always_comb begin
        unique case ({dec_ok, inc_ok})
            2'b01:   step_o = STEP_INC;
            2'b10:   step_o = STEP_DEC;
            default: step_o = STEP_HOLD;
        endcase
    end

endmodule

// File: rtl/bsc_count_core.sv
// Module: bsc_count_core
// Holds the count register and forms the visible count. Clear and load
// are applied to the register at the next clock and also bypass it
// combinationally, so their effect shows before any edge. Priority is:
// clear, then load, then step.
// Assumes: step_i is already qualified by bsc_step_decode.
module bsc_count_core
    import bsc_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  step_e        step_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    // Next stored value by priority: clear, load, step.
    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = ZERO;
        end else if (!load_n) begin
            cnt_d = din;
        end else begin
            unique case (step_i)
                STEP_INC: cnt_d = cnt_q + ONE;
                STEP_DEC: cnt_d = cnt_q - ONE;
                default:  cnt_d = cnt_q;
            endcase
        end
    end

    // Stored count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Visible count: overrides bypass the register.
    always_comb begin
        if (clr) begin
            count_o = ZERO;
        end else if (!load_n) begin
            count_o = din;
        end else begin
            count_o = cnt_q;
        end
    end

endmodule

// File: rtl/bsc_cascade_flags.sv
// Module: bsc_cascade_flags
// Forms the active-low carry and borrow. Each is gated by the low phase
// of its count input, so it rises with that input's next edge.
// Assumes: count_i is the visible count.
module bsc_cascade_flags #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] count_i,
    input  logic         up_pin,
    input  logic         dn_pin,
    output logic         carry_n,
    output logic         borrow_n
);

    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] BOT = '0;

    // Terminal-count detection gated by the count input's low phase.
    always_comb begin
        carry_n  = ~((count_i == TOP) & ~up_pin);
        borrow_n = ~((count_i == BOT) & ~dn_pin);
    end

endmodule

// File: rtl/bidir_step_counter.sv
// Module: bidir_step_counter (top)
// W-bit counter stepped up or down by rising edges on two separate count
// inputs, which the system clock samples. It has an immediate clear and
// load, plus active-low carry and borrow for cascading.
// Assumes: up_in and dn_in are synchronous to clk and toggle at no more
// than half the clk rate.
module bidir_step_counter
    import bsc_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_in,
    input  logic         dn_in,
    input  logic         clr,
    input  logic         load_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] count,
    output logic         carry_n,
    output logic         borrow_n
);

    logic [LANES-1:0] pins;
    logic [LANES-1:0] rises;
    step_e            step;

    // Gather the count inputs into lanes.
    always_comb begin
        pins[LANE_UP] = up_in;
        pins[LANE_DN] = dn_in;
    end

    // One edge detector per count input, both idling high.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        bsc_edge_detect #(.IDLE(1'b1)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins[i]),
            .rise_o (rises[i])
        );
    end

    bsc_step_decode u_decode (
        .up_pin  (up_in),
        .dn_pin  (dn_in),
        .up_rise (rises[LANE_UP]),
        .dn_rise (rises[LANE_DN]),
        .step_o  (step)
    );

    bsc_count_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .load_n  (load_n),
        .din     (din),
        .step_i  (step),
        .count_o (count)
    );

    bsc_cascade_flags #(.W(W)) u_flags (
        .count_i  (count),
        .up_pin   (up_in),
        .dn_pin   (dn_in),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

endmodule

// File: rtl/bsc_checker.sv
// Module: bsc_checker
// Port-level properties for bidir_step_counter, attached by bind.
// Keeps its own one-cycle history of the count inputs, reset to high.
module bsc_checker #(
    parameter int unsigned W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         up_in,
    input logic         dn_in,
    input logic         clr,
    input logic         load_n,
    input logic [W-1:0] din,
    input logic [W-1:0] count,
    input logic         carry_n,
    input logic         borrow_n
);

    logic up_d;
    logic dn_d;

    // Checker-side history of the count inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_d <= 1'b1;
            dn_d <= 1'b1;
        end else begin
            up_d <= up_in;
            dn_d <= dn_in;
        end
    end

    // R1 and R7: clear forces zero whatever load does.
    a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (count == '0));

    // R2: load shows the data.
    a_r2_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load_n) |-> (count == din));

    // R3: a qualified advance edge steps up by one.
    a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && up_in && !up_d && dn_in && dn_d)
        |=> (clr || !load_n || count == W'($past(count) + 1'b1)));

    // R4: a qualified retreat edge steps down by one.
    a_r4_dn_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && dn_in && !dn_d && up_in && up_d)
        |=> (clr || !load_n || count == W'($past(count) - 1'b1)));

    // R5: carry low only at all ones with up_in low.
    a_r5_carry_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (count == '1 && !up_in));

    // R6: borrow low only at zero with dn_in low.
    a_r6_borrow_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (count == '0 && !dn_in));

    // R8: an advance edge with dn_in low leaves the count alone.
    a_r8_up_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && up_in && !up_d && !dn_in && !dn_d)
        |=> (clr || !load_n || $stable(count)));

    // R9: simultaneous edges cancel.
    a_r9_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && up_in && !up_d && dn_in && !dn_d)
        |=> (clr || !load_n || $stable(count)));

endmodule

bind bidir_step_counter bsc_checker #(.W(W)) u_bsc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_in    (up_in),
    .dn_in    (dn_in),
    .clr      (clr),
    .load_n   (load_n),
    .din      (din),
    .count    (count),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
);

// File: tb/tb_bidir_step_counter.sv
// Directed bench for bidir_step_counter. Inputs change on the falling
// edge; outputs are sampled 1 ns later or at the falling edge.
module tb_bidir_step_counter;

    localparam int unsigned W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         up_in;
    logic         dn_in;
    logic         clr;
    logic         load_n;
    logic [W-1:0] din;
    logic [W-1:0] count;
    logic         carry_n;
    logic         borrow_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bidir_step_counter #(.W(W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_in    (up_in),
        .dn_in    (dn_in),
        .clr      (clr),
        .load_n   (load_n),
        .din      (din),
        .count    (count),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Load a value and release load one cycle later.
    task automatic load_val(input logic [W-1:0] v);
        @(negedge clk); din = v; load_n = 1'b0;
        @(negedge clk); load_n = 1'b1;
    endtask

    // One advance pulse: low two cycles, high two cycles.
    task automatic pulse_up();
        @(negedge clk); up_in = 1'b0;
        @(negedge clk);
        @(negedge clk); up_in = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_dn();
        @(negedge clk); dn_in = 1'b0;
        @(negedge clk);
        @(negedge clk); dn_in = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; up_in = 1'b1; dn_in = 1'b1;
        clr = 1'b0; load_n = 1'b1; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 count", int'(count), 0);
        chk("R10 carry_n", int'(carry_n), 1);
        chk("R10 borrow_n", int'(borrow_n), 1);
    endtask

    task automatic t_load_clear();
        @(negedge clk); din = 4'b1101; load_n = 1'b0;
        #1 chk("R2 immediate load", int'(count), 13);
        @(negedge clk); load_n = 1'b1;
        #1 chk("R11 hold after load", int'(count), 13);
        @(negedge clk); clr = 1'b1;
        #1 chk("R1 immediate clear", int'(count), 0);
        @(negedge clk); clr = 1'b0;
        #1 chk("R1 stored clear", int'(count), 0);
        @(negedge clk); clr = 1'b1; load_n = 1'b0; din = 4'd9;
        #1 chk("R7 clear over load", int'(count), 0);
        @(negedge clk); clr = 1'b0; load_n = 1'b1;
        #1 chk("R7 clear stored", int'(count), 0);
    endtask

    task automatic t_up_wrap();
        load_val(4'd13);
        pulse_up(); chk("R3 13->14", int'(count), 14);
        pulse_up(); chk("R3 14->15", int'(count), 15);
        pulse_up(); chk("R3 wrap 15->0", int'(count), 0);
        pulse_up(); chk("R3 0->1", int'(count), 1);
    endtask

    task automatic t_dn_wrap();
        load_val(4'd1);
        pulse_dn(); chk("R4 1->0", int'(count), 0);
        pulse_dn(); chk("R4 wrap 0->15", int'(count), 15);
        pulse_dn(); chk("R4 15->14", int'(count), 14);
    endtask

    task automatic t_carry_width();
        int low_cnt = 0;
        load_val(4'd15);
        #1 chk("R5 carry high while up high", int'(carry_n), 1);
        @(negedge clk); up_in = 1'b0;
        #1 chk("R5 carry low", int'(carry_n), 0);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            if (!carry_n) low_cnt++;
            up_in = (i == 1);
        end
        #1 chk("R5 carry rises with up_in", int'(carry_n), 1);
        chk("R5 carry low width", low_cnt, 2);
        @(negedge clk);
        chk("R5 wrapped to 0", int'(count), 0);
        chk("R5 carry high at 0", int'(carry_n), 1);
    endtask

    task automatic t_borrow_width();
        int low_cnt = 0;
        load_val(4'd0);
        @(negedge clk); dn_in = 1'b0;
        #1 chk("R6 borrow low", int'(borrow_n), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!borrow_n) low_cnt++;
            dn_in = (i == 2);
        end
        #1 chk("R6 borrow rises with dn_in", int'(borrow_n), 1);
        chk("R6 borrow low width", low_cnt, 3);
        @(negedge clk);
        chk("R6 wrapped to 15", int'(count), 15);
        chk("R6 borrow high at 15", int'(borrow_n), 1);
        load_val(4'd7);
        @(negedge clk); up_in = 1'b0;
        #1 chk("R5 no carry at 7", int'(carry_n), 1);
        @(negedge clk); up_in = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_ignore_other_low();
        load_val(4'd6);
        @(negedge clk); dn_in = 1'b0;
        pulse_up();
        chk("R8 up edge ignored", int'(count), 6);
        pulse_up();
        chk("R8 second up edge ignored", int'(count), 6);
        @(negedge clk); dn_in = 1'b1;
        @(negedge clk);
        chk("R4 dn rise with up high", int'(count), 5);
    endtask

    task automatic t_both_rise();
        load_val(4'd10);
        @(negedge clk); up_in = 1'b0; dn_in = 1'b0;
        @(negedge clk);
        @(negedge clk); up_in = 1'b1; dn_in = 1'b1;
        @(negedge clk);
        chk("R9 both rise hold", int'(count), 10);
        @(negedge clk);
        chk("R9 still held", int'(count), 10);
    endtask

    task automatic t_load_vs_edge();
        load_val(4'd3);
        @(negedge clk); up_in = 1'b0;
        @(negedge clk);
        @(negedge clk); up_in = 1'b1; din = 4'd5; load_n = 1'b0;
        @(negedge clk); load_n = 1'b1;
        #1 chk("R7 load beats up edge", int'(count), 5);
        @(negedge clk);
        chk("R11 loaded value held", int'(count), 5);
    endtask

    initial begin
        fork
            begin
                #200000;
                if (!done) begin
                    n_chk++; n_fail++;
                    $display("FAIL watchdog: actual timeout expected completion");
                    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
                    $finish;
                end
            end
        join_none
        t_reset();
        t_load_clear();
        t_up_wrap();
        t_dn_wrap();
        t_carry_width();
        t_borrow_width();
        t_ignore_other_low();
        t_both_rise();
        t_load_vs_edge();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule